// File: doc/BRIEF.md
# Host Bridge Reset and Strap Sequencer

This block creates the processor reset for a host bridge from two platform inputs: an active-low reset request and a power-good level. Reset-in low with power-good low is a full reset. Reset-in low with power-good high is a warm reset. Both high is normal operation. Reset-in high with power-good low should never happen, and the block flags it. The processor reset is released a programmable number of timebase ticks after reset-in goes away. A one-cycle release pulse tells the rest of the bridge which kind of reset just ended.

Strap pins are captured on the rising edge of power-good. The captured value survives warm resets, and it is cleared to zero only while power-good is low. One selected strap bit is driven onto a host address line through the whole reset window. It stays driven for a fixed number of clocks after the processor reset is released. A setup gate delays the release until that bit has been stable long enough.

Top module: `hb_rst_seq`

## Requirements
- R1: `rel_full` is sampled together with `rel_pulse`. It reads 1 if power-good was low at any time since the previous release (full reset) and 0 otherwise (warm reset).
- R2: If the synchronised reset-in is high while power-good is low, `state_err` is high one clock later and `cpu_rst_n` is held low. `state_err` is low during any reset with reset-in low.
- R3: `strap_q` takes the value of `strap_pins` at the first clock on which power-good is seen high. Changes on `strap_pins` after that clock have no effect on it.
- R4: `strap_q` reads all zeros while power-good is low. A warm reset keeps its value.
- R5: Reset-in is released and then passes a two-flop synchroniser. The sequencer enters its wait state on the third clock. From the fourth clock it counts clocks with `tick` high. `cpu_rst_n` goes high on the clock after the count reaches RELEASE_TICKS.
- R6: `cpu_rst_n` is not released until the strap value has been stable for SETUP_CLKS clocks after its capture clock. This means no earlier than the fifth clock after capture when SETUP_CLKS is 4.
- R7: `strap_oe` is high through the whole reset window. It falls exactly HOLD_CLKS (8) clocks after `cpu_rst_n` rises. While it is high, `strap_val` equals `strap_q[STRAP_SEL]` (bit 1 by default).
- R8: `rel_pulse` is high for exactly one clock, the first clock on which `cpu_rst_n` reads high.
- R9: When reset-in goes low, the synchroniser clears at once. `cpu_rst_n` reads low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| tick | input | 1 | Free-running timebase tick, one clock wide |
| pwr_ok | input | 1 | Power-good level, synchronous to clk |
| rst_in_n | input | 1 | Platform reset request, active low |
| strap_pins | input | STRAP_W | Strap inputs |
| cpu_rst_n | output | 1 | Processor reset, active low |
| strap_oe | output | 1 | Drive enable for the strap onto the host address line |
| strap_val | output | 1 | Strap bit to drive |
| strap_q | output | STRAP_W | Captured straps |
| rel_pulse | output | 1 | One-clock pulse at processor reset release |
| rel_full | output | 1 | Reset type at release: 1 full, 0 warm |
| state_err | output | 1 | Reset-in high with power-good low |

## Verification
The bench runs full and warm resets for every 4-bit strap value, with the tick arriving every clock, every second clock and every third clock. This separates the tick-counting latency from the fixed synchroniser delay. Full resets change the pins after capture, and warm resets change them before the reset. Together these tell the power-good edge capture apart from sticky retention and from pin tracking. In one extra case, power-good and reset-in rise together, so the setup gate rather than the tick count decides the release clock. Another case drops power-good while running, to check the error flag and the processor reset hold.

// File: rtl/hb_rst_pkg.sv
// Shared types for the host bridge reset sequencer.
// Assumes: HOLD must encode as zero so a cleared state register means "in reset".
package hb_rst_pkg;
    typedef enum logic [1:0] {
        SQ_HOLD  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_DRIVE = 2'd2,
        SQ_RUN   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/hb_rst_sync.sv
// Reset request synchroniser: clears at once when the request asserts,
// and releases through STAGES flops on the host clock.
// Assumes: async_n may change at any time relative to clk.
module hb_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in after release; clear the whole chain on assertion.
    always_ff @(posedge clk or negedge async_n) begin
        if (!async_n) chain <= '0;
        else          chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/hb_rst_classify.sv
// Power-good side of the sequencer: strap capture, strap setup timing,
// full/warm tracking and the impossible-state flag.
// Assumes: pwr_ok is synchronous to clk; this logic is reset by power-good
// itself (sticky domain), not by reset-in.
module hb_rst_classify #(
    parameter int STRAP_W    = 4,
    parameter int SETUP_CLKS = 4
) (
    input  logic               clk,
    input  logic               rst_s_n,
    input  logic               pwr_ok,
    input  logic [STRAP_W-1:0] strap_pins,
    input  logic               release_go,
    output logic [STRAP_W-1:0] strap_q,
    output logic               setup_ok,
    output logic               full_seen,
    output logic               state_err
);
    localparam int SCW = $clog2(SETUP_CLKS + 1);

    logic           pg_q;
    logic [SCW-1:0] scnt;

    // Previous power-good level for rising edge detection.
    always_ff @(posedge clk) begin
        pg_q <= pwr_ok;
    end

    // Straps: zero while power is bad, captured on the first good clock, held otherwise.
    always_ff @(posedge clk) begin
        if (!pwr_ok)   strap_q <= '0;
        else if (!pg_q) strap_q <= strap_pins;
    end

    // Count clocks of strap stability since capture, saturating at SETUP_CLKS.
    always_ff @(posedge clk) begin
        if (!pwr_ok || !pg_q)             scnt <= '0;
        else if (scnt != SCW'(SETUP_CLKS)) scnt <= scnt + 1'b1;
    end

    assign setup_ok = (scnt == SCW'(SETUP_CLKS));

    // Remember any power-good loss until the next processor reset release.
    always_ff @(posedge clk) begin
        if (!pwr_ok)         full_seen <= 1'b1;
        else if (release_go) full_seen <= 1'b0;
    end

    // Flag reset-in released while power is not good.
    always_ff @(posedge clk) begin
        state_err <= rst_s_n && !pwr_ok;
    end

    assert_strap_capture_R3: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(pwr_ok) |=> (strap_q == $past(strap_pins)));

    assert_strap_sticky_R3: assert property (@(posedge clk) disable iff (!pwr_ok)
        (pwr_ok && pg_q) |=> $stable(strap_q));
endmodule

// File: rtl/hb_rst_release.sv
// Release sequencer: holds the processor in reset, counts timebase ticks
// after reset-in is released, waits for strap setup, then releases and keeps
// the strap driven for HOLD_CLKS clocks.
// Assumes: rst_s_n is already synchronised; tick is one clock wide.
module hb_rst_release
    import hb_rst_pkg::*;
#(
    parameter int RELEASE_TICKS = 1000,
    parameter int HOLD_CLKS     = 8
) (
    input  logic clk,
    input  logic rst_s_n,
    input  logic pwr_ok,
    input  logic tick,
    input  logic setup_ok,
    output logic release_go,
    output logic cpu_rst_n,
    output logic strap_oe,
    output logic rel_pulse
);
    localparam int TW = $clog2(RELEASE_TICKS + 1);
    localparam int HW = $clog2(HOLD_CLKS);

    seq_state_t    state;
    logic [TW-1:0] tcnt;
    logic [HW-1:0] hcnt;

    assign release_go = (state == SQ_WAIT) && (tcnt == TW'(RELEASE_TICKS)) && setup_ok;

    // Sequence reset window, tick wait, strap hold and run.
    always_ff @(posedge clk) begin
        if (!rst_s_n || !pwr_ok) begin
            state     <= SQ_HOLD;
            tcnt      <= '0;
            hcnt      <= '0;
            rel_pulse <= 1'b0;
        end else begin
            rel_pulse <= 1'b0;
            case (state)
                SQ_HOLD: begin
                    state <= SQ_WAIT;
                    tcnt  <= '0;
                end
                SQ_WAIT: begin
                    if (release_go) begin
                        state     <= SQ_DRIVE;
                        hcnt      <= '0;
                        rel_pulse <= 1'b1;
                    end else if (tick && (tcnt != TW'(RELEASE_TICKS))) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SQ_DRIVE: begin
                    if (hcnt == HW'(HOLD_CLKS - 1)) state <= SQ_RUN;
                    else                            hcnt  <= hcnt + 1'b1;
                end
                default: state <= SQ_RUN;
            endcase
        end
    end

    assign cpu_rst_n = (state == SQ_DRIVE) || (state == SQ_RUN);
    assign strap_oe  = (state != SQ_RUN);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
        rel_pulse |=> !rel_pulse);

    assert_pulse_at_release_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
        rel_pulse |-> $rose(cpu_rst_n));

    assert_min_hold_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
        $fell(strap_oe) |-> $past(cpu_rst_n, 2));

    assert_setup_met_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
        $rose(cpu_rst_n) |-> $past(setup_ok));
endmodule

// File: rtl/hb_rst_seq.sv
// Top of the host bridge reset sequencer: synchronises reset-in, tracks
// power-good and straps, and times processor reset release and strap drive.
// Assumes: pwr_ok and tick are synchronous to clk.
module hb_rst_seq #(
    parameter int STRAP_W       = 4,
    parameter int STRAP_SEL     = 1,
    parameter int RELEASE_TICKS = 1000,
    parameter int SETUP_CLKS    = 4,
    parameter int HOLD_CLKS     = 8
) (
    input  logic               clk,
    input  logic               tick,
    input  logic               pwr_ok,
    input  logic               rst_in_n,
    input  logic [STRAP_W-1:0] strap_pins,
    output logic               cpu_rst_n,
    output logic               strap_oe,
    output logic               strap_val,
    output logic [STRAP_W-1:0] strap_q,
    output logic               rel_pulse,
    output logic               rel_full,
    output logic               state_err
);
    logic rst_s_n;
    logic release_go;
    logic setup_ok;
    logic full_seen;

    hb_rst_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .async_n (rst_in_n),
        .sync_n  (rst_s_n)
    );

    hb_rst_classify #(.STRAP_W(STRAP_W), .SETUP_CLKS(SETUP_CLKS)) u_cls (
        .clk        (clk),
        .rst_s_n    (rst_s_n),
        .pwr_ok     (pwr_ok),
        .strap_pins (strap_pins),
        .release_go (release_go),
        .strap_q    (strap_q),
        .setup_ok   (setup_ok),
        .full_seen  (full_seen),
        .state_err  (state_err)
    );

    hb_rst_release #(.RELEASE_TICKS(RELEASE_TICKS), .HOLD_CLKS(HOLD_CLKS)) u_rel (
        .clk        (clk),
        .rst_s_n    (rst_s_n),
        .pwr_ok     (pwr_ok),
        .tick       (tick),
        .setup_ok   (setup_ok),
        .release_go (release_go),
        .cpu_rst_n  (cpu_rst_n),
        .strap_oe   (strap_oe),
        .rel_pulse  (rel_pulse)
    );

    // Capture the reset type on the release clock so it aligns with rel_pulse.
    always_ff @(posedge clk) begin
        if (release_go) rel_full <= full_seen;
    end

    assign strap_val = strap_q[STRAP_SEL];

    assert_err_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
        state_err |-> !cpu_rst_n);

    assert_warm_keeps_power_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
        rel_pulse |-> pwr_ok);
endmodule

// File: tb/tb_hb_rst_seq.sv
module tb_hb_rst_seq;
    localparam int SW   = 4;
    localparam int SEL  = 1;
    localparam int NT   = 1;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          tick = 1'b0, pwr_ok = 1'b0, rst_in_n = 1'b0;
    logic [SW-1:0] strap_pins = '0;
    logic          cpu_rst_n, strap_oe, strap_val, rel_pulse, rel_full, state_err;
    logic [SW-1:0] strap_q;

    int n_cmp = 0, n_bad = 0, e = 0, D = 1;
    bit done = 0;

    hb_rst_seq #(.STRAP_W(SW), .STRAP_SEL(SEL), .RELEASE_TICKS(NT),
                 .SETUP_CLKS(4), .HOLD_CLKS(HOLD)) dut (
        .clk(clk), .tick(tick), .pwr_ok(pwr_ok), .rst_in_n(rst_in_n),
        .strap_pins(strap_pins), .cpu_rst_n(cpu_rst_n), .strap_oe(strap_oe),
        .strap_val(strap_val), .strap_q(strap_q), .rel_pulse(rel_pulse),
        .rel_full(rel_full), .state_err(state_err));

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, e, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        e++;
        tick = (((e + 1) % D) == 0);
    endtask

    // Edge of the NT-th counted tick; counting starts on the fourth edge.
    function automatic int tick_edge(int d);
        int t = 3;
        int c = 0;
        while (c < NT) begin
            t++;
            if ((t % d) == 0) c++;
        end
        return t;
    endfunction

    task automatic release_and_check(int d, int exp_full, int min_rel, logic [SW-1:0] s);
        int rel;
        D = d;
        e = 0;
        tick = ((1 % d) == 0);
        rst_in_n = 1'b1;
        rel = tick_edge(d) + 1;
        if (rel < min_rel) rel = min_rel;
        while (e < rel + HOLD + 2) begin
            step();
            chk("R5 cpu_rst_n", int'(cpu_rst_n), int'(e >= rel));
            chk("R8 rel_pulse", int'(rel_pulse), int'(e == rel));
            if (e == rel) chk("R1 rel_full", int'(rel_full), exp_full);
            chk("R7 strap_oe", int'(strap_oe), int'(e < rel + HOLD));
            if (e < rel + HOLD) chk("R7 strap_val", int'(strap_val), int'(s[SEL]));
        end
        chk("R3 strap_q", int'(strap_q), int'(s));
    endtask

    initial begin
        D = 1;
        repeat (3) step();
        chk("R9 reset cpu_rst_n", int'(cpu_rst_n), 0);
        chk("R7 reset strap_oe", int'(strap_oe), 1);
        chk("R4 reset strap_q", int'(strap_q), 0);
        chk("R2 reset state_err", int'(state_err), 0);
        chk("R8 reset rel_pulse", int'(rel_pulse), 0);

        for (int d = 1; d <= 3; d++) begin
            for (int s = 0; s < 16; s++) begin
                // Full reset: capture on power-good rise, pins changed afterwards.
                pwr_ok = 1'b0; rst_in_n = 1'b0; strap_pins = SW'(s);
                step();
                chk("R9 cpu_rst_n after assert", int'(cpu_rst_n), 0);
                step(); step();
                chk("R4 strap_q zero while power bad", int'(strap_q), 0);
                chk("R2 no error in full reset", int'(state_err), 0);
                pwr_ok = 1'b1;
                step();
                strap_pins = ~SW'(s);
                repeat (5) step();
                chk("R3 strap_q after capture", int'(strap_q), s);
                release_and_check(d, 1, 0, SW'(s));
                // Warm reset: pins differ, captured value must be kept.
                strap_pins = SW'(s) ^ 4'h5;
                rst_in_n = 1'b0;
                step();
                chk("R9 cpu_rst_n after warm assert", int'(cpu_rst_n), 0);
                repeat (4) step();
                chk("R4 strap_q kept in warm reset", int'(strap_q), s);
                chk("R2 no error in warm reset", int'(state_err), 0);
                release_and_check(d, 0, 0, SW'(s));
            end
        end

        // Illegal state: power-good drops while reset-in is high.
        pwr_ok = 1'b0;
        step();
        chk("R2 state_err on illegal", int'(state_err), 1);
        chk("R2 cpu_rst_n held on illegal", int'(cpu_rst_n), 0);
        chk("R4 strap_q cleared", int'(strap_q), 0);
        rst_in_n = 1'b0;
        step();
        chk("R2 state_err cleared in reset", int'(state_err), 0);

        // Setup gate: power-good and reset-in rise together.
        strap_pins = 4'hA;
        repeat (2) step();
        pwr_ok = 1'b1;
        release_and_check(1, 1, 6, 4'hA);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule